// File: doc/BRIEF.md
# Second-Chance Victim Frame Selector

This block chooses which physical frame to evict when memory is full, using the second-chance clock policy. The frames form a ring, and each frame has one reference bit. An access notification carries a frame index and sets that frame's bit. A rotating hand marks the next frame to inspect.

On a replace request the block sweeps forward from the hand and inspects one frame per clock cycle. A frame whose bit is set loses the bit and is passed over. The first frame found with a clear bit becomes the victim. The victim index is presented with a one-cycle done strobe, and the hand then rests on the frame after the victim. Because a sweep can run from one cycle up to one full lap plus one, the selection latency varies. A busy output covers the whole sweep.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset, busy and done are low, every reference bit is clear and the hand is on frame 0, so the first replace request returns frame 0 after a single inspection.
- R2: A cycle with acc_valid high sets the reference bit of the frame numbered acc_frame.
- R3: A sweep inspects frames starting at the hand and moving to increasing indices, wrapping from frame NUM_FRAMES-1 to frame 0.
- R4: One frame is inspected per clock cycle. An inspected frame with its bit set has that bit cleared and is skipped.
- R5: The first inspected frame with a clear bit is the victim. On the k-th clock edge after the request is accepted, where k is the number of frames inspected, done goes high for exactly one cycle and victim holds that frame's index.
- R6: After a victim is chosen, the hand points to (victim + 1) mod NUM_FRAMES.
- R7: If every bit is set when the sweep starts, all bits are cleared and the frame at the starting hand position is returned after NUM_FRAMES+1 inspections.
- R8: An access to the frame being inspected in the same cycle leaves that frame's bit set; the set wins over the clear.
- R9: busy rises on the edge that accepts a request and falls on the edge where done rises. done and busy are never high together.
- R10: A replace request that arrives while busy is high is ignored. It neither restarts nor extends the sweep, and it produces no extra done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | Access notification strobe |
| acc_frame | input | IDX_W | Index of the frame that was accessed |
| repl_req | input | 1 | Request to choose a victim |
| busy | output | 1 | A sweep is in progress |
| done | output | 1 | One-cycle strobe: victim is valid |
| victim | output | IDX_W | Index of the chosen frame |

## Verification
The bench uses six reference patterns, each applied in turn from the hand position the previous one left behind: no bits set, a short run of set bits ahead of the hand, every bit set, and a run that crosses the wrap from the top frame to frame 0. Comparing these separates the single-cycle hit, skip-and-clear, full-lap and wraparound behaviours through the victim index and the cycle count. Directed runs then check three more things. An access timed to land on the frame under inspection must survive the sweep, which shows itself in a later victim choice. A second request sent mid-sweep must produce no second strobe. A reset in the middle of a sweep must bring the hand back to frame 0.

// File: rtl/clock_sel_pkg.sv
package clock_sel_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } sweep_state_t;

  // Next ring position; the frame count is a power of two, so the index wraps naturally.
  function automatic logic [7:0] ring_next(input logic [7:0] idx, input int unsigned n);
    logic [7:0] r;
    r = (idx + 8'd1) & 8'(n - 1);
    return r;
  endfunction

endpackage

// File: rtl/ref_bit_array.sv
module ref_bit_array #(
  parameter int NUM_FRAMES = 16,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);

  logic [NUM_FRAMES-1:0] ref_q;
  logic                  set_hits_clr;

  assign set_hits_clr = set_en && clr_en && (set_idx == clr_idx);

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_bit
    logic set_me, clr_me;
    assign set_me = set_en && (set_idx == IDX_W'(g));
    assign clr_me = clr_en && (clr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)      ref_q[g] <= 1'b0;
      else if (set_me) ref_q[g] <= 1'b1;
      else if (clr_me) ref_q[g] <= 1'b0;
    end
  end

  assign rd_bit = ref_q[rd_idx];

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ref_q[$past(set_idx)]);

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_hits_clr) |=> !ref_q[$past(clr_idx)]);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_hits_clr |=> ref_q[$past(clr_idx)]);

endmodule

// File: rtl/hand_ctrl.sv
module hand_ctrl
  import clock_sel_pkg::*;
#(
  parameter int NUM_FRAMES = 16,
  localparam int IDX_W = $clog2(NUM_FRAMES),
  localparam int CNT_W = IDX_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             repl_req,
  input  logic             cur_ref,
  output logic [IDX_W-1:0] hand,
  output logic             inspect,
  output logic             skip,
  output logic             found,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] victim
);

  sweep_state_t     state_q;
  logic [IDX_W-1:0] hand_q, hand_nx;
  logic [CNT_W-1:0] sweep_cnt;
  logic             accept;

  assign hand_nx = IDX_W'(ring_next(8'(hand_q), NUM_FRAMES));
  assign accept  = (state_q == ST_IDLE) && repl_req;
  assign inspect = (state_q == ST_SWEEP);
  assign skip    = inspect && cur_ref;
  assign found   = inspect && !cur_ref;
  assign hand    = hand_q;
  assign busy    = inspect;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      hand_q    <= '0;
      done      <= 1'b0;
      victim    <= '0;
      sweep_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        state_q   <= ST_SWEEP;
        sweep_cnt <= '0;
      end else if (inspect) begin
        hand_q    <= hand_nx;
        sweep_cnt <= sweep_cnt + 1'b1;
        if (found) begin
          state_q <= ST_IDLE;
          victim  <= hand_q;
          done    <= 1'b1;
        end
      end
    end
  end

  assert_sweep_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inspect |-> (sweep_cnt <= CNT_W'(NUM_FRAMES)));

  assert_hold_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    skip |=> busy);

  assert_one_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    skip |=> (hand == IDX_W'(ring_next(8'($past(hand)), NUM_FRAMES))));

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NUM_FRAMES = 16,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_frame,
  input  logic             repl_req,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] victim
);

  logic [IDX_W-1:0] hand;
  logic             cur_ref, inspect, skip, found;

  ref_bit_array #(.NUM_FRAMES(NUM_FRAMES)) i_bits (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (acc_valid),
    .set_idx (acc_frame),
    .clr_en  (skip),
    .clr_idx (hand),
    .rd_idx  (hand),
    .rd_bit  (cur_ref)
  );

  hand_ctrl #(.NUM_FRAMES(NUM_FRAMES)) i_hand (
    .clk      (clk),
    .rst_n    (rst_n),
    .repl_req (repl_req),
    .cur_ref  (cur_ref),
    .hand     (hand),
    .inspect  (inspect),
    .skip     (skip),
    .found    (found),
    .busy     (busy),
    .done     (done),
    .victim   (victim)
  );

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hand_after_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hand == IDX_W'(victim + 1'b1)));

  assert_found_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    found |=> (done && victim == $past(hand)));

endmodule

// File: tb/test_clock_victim_sel.sv
module test_clock_victim_sel;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int IW = 4;

  // {access mask[31:16], expected victim[15:8], expected inspections[7:0]}
  localparam logic [31:0] VEC [6] = '{
    {16'h0000, 8'd0,  8'd1},   // R1: nothing set, hand 0
    {16'h0006, 8'd3,  8'd3},   // R4: two set frames ahead
    {16'hFFFF, 8'd4,  8'd17},  // R7: full lap from hand 4
    {16'h03E0, 8'd10, 8'd6},   // R4: run of five
    {16'hF801, 8'd1,  8'd7},   // R3: run across wrap
    {16'h0000, 8'd2,  8'd1}    // R6: hand rests past victim
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [IW-1:0] acc_frame = '0;
  logic repl_req = 1'b0;
  logic busy, done;
  logic [IW-1:0] victim;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clock_victim_sel #(.NUM_FRAMES(N)) i_clock_victim_sel (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_frame(acc_frame),
    .repl_req(repl_req), .busy(busy), .done(done), .victim(victim)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic touch_mask(input logic [N-1:0] m);
    for (int f = 0; f < N; f++) begin
      if (m[f]) begin
        acc_valid = 1'b1; acc_frame = IW'(f);
        @(negedge clk);
      end
    end
    acc_valid = 1'b0;
  endtask

  // Issue a request; optionally inject an access on inspection acc_at and a stray request on req_at.
  task automatic replace(input int exp_v, input int exp_c, input string req,
                         input int acc_at, input int acc_f, input int req_at);
    int cyc;
    repl_req = 1'b1;
    @(negedge clk);
    repl_req = 1'b0;
    check(busy === 1'b1, "R9", busy, 1);
    cyc = 0;
    while (!done && cyc < 3*N) begin
      acc_valid = (cyc + 1 == acc_at);
      acc_frame = IW'(acc_f);
      repl_req  = (cyc + 1 == req_at);
      @(negedge clk);
      cyc++;
      if (!done) check(busy === 1'b1, "R9", busy, 1);
    end
    acc_valid = 1'b0; repl_req = 1'b0;
    check(done === 1'b1 && busy === 1'b0, "R9", busy, 0);
    check(int'(victim) == exp_v, req, victim, exp_v);
    check(cyc == exp_c, req, cyc, exp_c);
    @(negedge clk);
    check(done === 1'b0, "R5", done, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R1", busy, 0);
    check(done === 1'b0, "R1", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      touch_mask(VEC[v][31:16]);
      replace(int'(VEC[v][15:8]), int'(VEC[v][7:0]), "R5", 0, 0, 0);
    end
    // hand now 3, all clear. R8: access frame 5 on its own inspection (3rd);
    // R10: stray request on inspection 6.
    touch_mask(16'hFFFF);
    replace(3, 17, "R8", 3, 5, 6);
    repeat (3) begin
      check(done === 1'b0 && busy === 1'b0, "R10", busy, 0);
      @(negedge clk);
    end
    replace(4, 1, "R6", 0, 0, 0);
    replace(6, 2, "R8", 0, 0, 0);   // frame 5 kept its bit
    // R2: a single access sets its bit, seen at hand 7
    touch_mask(16'h0080);
    replace(8, 2, "R2", 0, 0, 0);
    // R1: reset mid-sweep returns hand to 0
    touch_mask(16'hFFFF);
    repl_req = 1'b1; @(negedge clk); repl_req = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0; @(negedge clk);
    check(busy === 1'b0, "R1", busy, 0);
    rst_n = 1'b1; @(negedge clk);
    replace(0, 1, "R1", 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule